// File: doc/BRIEF.md
# Symbol Stream Packet Framer

The framer sits behind an 8b/10b decoder and turns its stream of decoded symbols into fixed-length packets. Each symbol arrives with a valid strobe and two qualifiers: one marking a control character, one marking a symbol the decoder could not decode. Data bytes are written into a packet buffer at a running write position. When the buffer holds a full packet, a ready flag is raised. The packet stays frozen until the consumer pulses an acknowledge.

Two control characters frame the stream. The start character (K28.1, code 0x3C) always synchronises the framer, sets the position to zero and emits a one-cycle request to reset the descrambler. The restart character (K27.7, code 0xFB) rewinds the position only while the framer is already synchronised. Any other control character drops synchronisation.

Three saturating counters record the faults: decode errors, bytes that would overrun a buffer that is full but already acknowledged, and bytes that arrive while the previous packet is still unconsumed.

Top module: `sym_framer`

## Requirements
- R1: After reset, pkt_ready, frame_sync, scr_reset, pkt_data and all three counters are zero.
- R2: A valid, error-free control symbol with code 0x3C synchronises the framer, sets the write position to 0 and drives scr_reset high for exactly the following cycle.
- R3: A valid, error-free control symbol with code 0xFB sets the write position to 0 when frame_sync is high. When frame_sync is low, the framer stays unsynchronised.
- R4: Any other valid, error-free control code clears frame_sync.
- R5: A valid data byte that arrives while the framer is synchronised, pkt_ready is low and the position is below PKT_LEN is stored at the current position and the position advances. Byte k sits in pkt_data[8k+7:8k]. When the PKT_LEN-th byte is stored, pkt_ready is high from the next cycle.
- R6: A one-cycle pkt_ack clears pkt_ready from the following cycle. pkt_data holds still while pkt_ready is high.
- R7: A data byte that arrives while the framer is unsynchronised is discarded and no counter changes.
- R8: A synchronised data byte that arrives while pkt_ready is high is a processing overflow, including in the cycle pkt_ack is pulsed. It increments proc_ovf_cnt, clears frame_sync and leaves pkt_data unchanged.
- R9: A synchronised data byte that arrives with pkt_ready low and the position equal to PKT_LEN is a receive overflow. It increments rx_ovf_cnt and clears frame_sync.
- R10: A valid symbol with sym_err high increments dec_err_cnt, whatever its other qualifiers. It does not change frame_sync, the write position or scr_reset.
- R11: Every counter saturates at 2^CNT_W-1.
- R12: Inputs are ignored while sym_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_ctrl | input | 1 | The symbol is a control character |
| sym_err | input | 1 | The decoder flagged the symbol as invalid |
| sym_byte | input | 8 | Data byte or control code |
| pkt_ack | input | 1 | One-cycle pulse from the consumer that releases the packet |
| pkt_ready | output | 1 | A full packet is held in pkt_data |
| pkt_data | output | PKT_LEN*8 | Packet buffer, byte 0 in the low bits |
| frame_sync | output | 1 | The framer is synchronised |
| scr_reset | output | 1 | One-cycle request to reset the descrambler |
| dec_err_cnt | output | CNT_W | Decode-error count |
| rx_ovf_cnt | output | CNT_W | Receive-overflow count |
| proc_ovf_cnt | output | CNT_W | Processing-overflow count |

## Verification
The checker watches every cycle for the local cause-and-effect rules:
- what each control code does to synchronisation and to the reset request;
- the frozen buffer while a packet is pending;
- acknowledge release;
- decode errors leaving framing alone;
- counter increments and saturation.

Some behaviour depends on the hidden write position, and only the bench's symbol sequences can show it. That covers three cases: restart rewinding mid-packet, a decode error not advancing the position, and the receive overflow after an acknowledged full buffer. The bench also checks packet contents byte by byte.

// File: rtl/sym_framer_pkg.sv
package sym_framer_pkg;

  // Symbol classes seen by the framing control
  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_DECERR  = 3'd1,
    EV_START   = 3'd2,
    EV_RESTART = 3'd3,
    EV_OTHER_K = 3'd4,
    EV_DATA    = 3'd5
  } sym_ev_e;

  localparam int NUM_CNT = 3;
  localparam int CNT_DEC  = 0;
  localparam int CNT_RX   = 1;
  localparam int CNT_PROC = 2;

endpackage

// File: rtl/sym_framer_classify.sv
module sym_framer_classify
  import sym_framer_pkg::*;
#(
  parameter logic [7:0] START_K   = 8'h3C,
  parameter logic [7:0] RESTART_K = 8'hFB
) (
  input  logic       sym_valid,
  input  logic       sym_ctrl,
  input  logic       sym_err,
  input  logic [7:0] sym_byte,
  output sym_ev_e    ev
);

  always_comb begin
    ev = EV_NONE;
    if (sym_valid) begin
      if (sym_err) begin
        ev = EV_DECERR;
      end else if (sym_ctrl) begin
        if (sym_byte == START_K) begin
          ev = EV_START;
        end else if (sym_byte == RESTART_K) begin
          ev = EV_RESTART;
        end else begin
          ev = EV_OTHER_K;
        end
      end else begin
        ev = EV_DATA;
      end
    end
  end

endmodule

// File: rtl/sym_framer_ctrl.sv
module sym_framer_ctrl
  import sym_framer_pkg::*;
#(
  parameter  int PKT_LEN = 8,
  localparam int POS_W   = $clog2(PKT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sym_ev_e          ev,
  input  logic             ack,
  output logic             wr_en,
  output logic [POS_W-1:0] wr_idx,
  output logic             pkt_ready,
  output logic             in_sync,
  output logic             scr_reset,
  output logic             inc_rx,
  output logic             inc_proc
);

  localparam logic [POS_W-1:0] POS_FULL = POS_W'(PKT_LEN);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_LEN - 1);

  logic [POS_W-1:0] pos_q, pos_n;
  logic             sync_q, sync_n;
  logic             ready_q, ready_n;
  logic             scr_q, scr_n;
  logic             state_en;

  // Next-state logic
  always_comb begin
    pos_n    = pos_q;
    sync_n   = sync_q;
    ready_n  = ready_q & ~ack;
    scr_n    = 1'b0;
    wr_en    = 1'b0;
    inc_rx   = 1'b0;
    inc_proc = 1'b0;
    unique case (ev)
      EV_START: begin
        sync_n = 1'b1;
        pos_n  = '0;
        scr_n  = 1'b1;
      end
      EV_RESTART: begin
        if (sync_q) begin
          pos_n = '0;
        end
      end
      EV_OTHER_K: begin
        sync_n = 1'b0;
        pos_n  = '0;
      end
      EV_DATA: begin
        if (sync_q) begin
          if (ready_q) begin
            sync_n   = 1'b0;
            pos_n    = '0;
            inc_proc = 1'b1;
          end else if (pos_q == POS_FULL) begin
            sync_n = 1'b0;
            pos_n  = '0;
            inc_rx = 1'b1;
          end else begin
            wr_en = 1'b1;
            pos_n = pos_q + POS_W'(1);
            if (pos_q == POS_LAST) begin
              ready_n = 1'b1;
            end
          end
        end
      end
      default: begin
      end
    endcase
  end

  assign state_en = (ev != EV_NONE) | ack | scr_q;

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      sync_q  <= 1'b0;
      ready_q <= 1'b0;
      scr_q   <= 1'b0;
    end else if (state_en) begin
      pos_q   <= pos_n;
      sync_q  <= sync_n;
      ready_q <= ready_n;
      scr_q   <= scr_n;
    end
  end

  assign wr_idx    = pos_q;
  assign pkt_ready = ready_q;
  assign in_sync   = sync_q;
  assign scr_reset = scr_q;

endmodule

// File: rtl/sym_framer_buf.sv
module sym_framer_buf #(
  parameter  int PKT_LEN = 8,
  localparam int POS_W   = $clog2(PKT_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [POS_W-1:0]     wr_idx,
  input  logic [7:0]           wr_byte,
  output logic [PKT_LEN*8-1:0] bytes
);

  for (genvar g = 0; g < PKT_LEN; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_we;

    assign slot_we = wr_en & (wr_idx == POS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_we) begin
        slot_q <= wr_byte;
      end
    end

    assign bytes[g*8 +: 8] = slot_q;
  end

endmodule

// File: rtl/sym_framer_satcnt.sv
module sym_framer_satcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_n  = cnt_q + W'(1);
    cnt_en = inc & ~(&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/sym_framer.sv
module sym_framer
  import sym_framer_pkg::*;
#(
  parameter int         PKT_LEN   = 8,
  parameter int         CNT_W     = 8,
  parameter logic [7:0] START_K   = 8'h3C,
  parameter logic [7:0] RESTART_K = 8'hFB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_valid,
  input  logic                 sym_ctrl,
  input  logic                 sym_err,
  input  logic [7:0]           sym_byte,
  input  logic                 pkt_ack,
  output logic                 pkt_ready,
  output logic [PKT_LEN*8-1:0] pkt_data,
  output logic                 frame_sync,
  output logic                 scr_reset,
  output logic [CNT_W-1:0]     dec_err_cnt,
  output logic [CNT_W-1:0]     rx_ovf_cnt,
  output logic [CNT_W-1:0]     proc_ovf_cnt
);

  localparam int POS_W = $clog2(PKT_LEN + 1);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  sym_ev_e          ev;
  logic             wr_en;
  logic [POS_W-1:0] wr_idx;
  logic             inc_rx;
  logic             inc_proc;
  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

  sym_framer_classify #(
    .START_K   (START_K),
    .RESTART_K (RESTART_K)
  ) u_classify (
    .sym_valid (sym_valid),
    .sym_ctrl  (sym_ctrl),
    .sym_err   (sym_err),
    .sym_byte  (sym_byte),
    .ev        (ev)
  );

  sym_framer_ctrl #(
    .PKT_LEN (PKT_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ev        (ev),
    .ack       (pkt_ack),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .pkt_ready (pkt_ready),
    .in_sync   (frame_sync),
    .scr_reset (scr_reset),
    .inc_rx    (inc_rx),
    .inc_proc  (inc_proc)
  );

  sym_framer_buf #(
    .PKT_LEN (PKT_LEN)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_byte (sym_byte),
    .bytes   (pkt_data)
  );

  always_comb begin
    inc_vec           = '0;
    inc_vec[CNT_DEC]  = (ev == EV_DECERR);
    inc_vec[CNT_RX]   = inc_rx;
    inc_vec[CNT_PROC] = inc_proc;
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    sym_framer_satcnt #(
      .W (CNT_W)
    ) u_satcnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (inc_vec[c]),
      .count (cnt_arr[c])
    );
  end

  assign dec_err_cnt  = cnt_arr[CNT_DEC];
  assign rx_ovf_cnt   = cnt_arr[CNT_RX];
  assign proc_ovf_cnt = cnt_arr[CNT_PROC];

endmodule

// File: rtl/sym_framer_chk.sv
module sym_framer_chk #(
  parameter int         PKT_LEN   = 8,
  parameter int         CNT_W     = 8,
  parameter logic [7:0] START_K   = 8'h3C,
  parameter logic [7:0] RESTART_K = 8'hFB
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sym_valid,
  input logic                 sym_ctrl,
  input logic                 sym_err,
  input logic [7:0]           sym_byte,
  input logic                 pkt_ack,
  input logic                 pkt_ready,
  input logic [PKT_LEN*8-1:0] pkt_data,
  input logic                 frame_sync,
  input logic                 scr_reset,
  input logic [CNT_W-1:0]     dec_err_cnt,
  input logic [CNT_W-1:0]     rx_ovf_cnt,
  input logic [CNT_W-1:0]     proc_ovf_cnt
);

  logic good, is_start, is_restart, is_other_k, is_data;

  assign good       = sym_valid & ~sym_err;
  assign is_start   = good & sym_ctrl & (sym_byte == START_K);
  assign is_restart = good & sym_ctrl & (sym_byte == RESTART_K);
  assign is_other_k = good & sym_ctrl & ~is_start & ~is_restart;
  assign is_data    = good & ~sym_ctrl;

  AST_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |=> frame_sync && scr_reset); // R2

  AST_SCR_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    !is_start |=> !scr_reset); // R2

  AST_RESTART_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    is_restart && !frame_sync |=> !frame_sync); // R3

  AST_OTHER_K_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    is_other_k |=> !frame_sync); // R4

  AST_READY_ONLY_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready && !is_data |=> !pkt_ready); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready && pkt_ack |=> !pkt_ready); // R6

  AST_FROZEN_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> $stable(pkt_data)); // R6

  AST_UNSYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_data && !frame_sync |=> !frame_sync && $stable(rx_ovf_cnt) && $stable(proc_ovf_cnt) && $stable(dec_err_cnt)); // R7

  AST_PROC_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_data && frame_sync && pkt_ready && !(&proc_ovf_cnt)
    |=> !frame_sync && (proc_ovf_cnt == CNT_W'($past(proc_ovf_cnt) + 1'b1))); // R8

  AST_DECERR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_err && !(&dec_err_cnt)
    |=> dec_err_cnt == CNT_W'($past(dec_err_cnt) + 1'b1)); // R10

  AST_DECERR_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && sym_err |=> $stable(frame_sync) && !scr_reset); // R10

  AST_DEC_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    &dec_err_cnt |=> &dec_err_cnt); // R11

  AST_RX_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    &rx_ovf_cnt |=> &rx_ovf_cnt); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid && !pkt_ack |=> $stable(frame_sync) && $stable(pkt_ready) && $stable(pkt_data)); // R12

endmodule

bind sym_framer sym_framer_chk #(
  .PKT_LEN   (PKT_LEN),
  .CNT_W     (CNT_W),
  .START_K   (START_K),
  .RESTART_K (RESTART_K)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .sym_valid    (sym_valid),
  .sym_ctrl     (sym_ctrl),
  .sym_err      (sym_err),
  .sym_byte     (sym_byte),
  .pkt_ack      (pkt_ack),
  .pkt_ready    (pkt_ready),
  .pkt_data     (pkt_data),
  .frame_sync   (frame_sync),
  .scr_reset    (scr_reset),
  .dec_err_cnt  (dec_err_cnt),
  .rx_ovf_cnt   (rx_ovf_cnt),
  .proc_ovf_cnt (proc_ovf_cnt)
);

// File: tb/sym_framer_tb.sv
module sym_framer_tb;

  localparam int PKT_LEN = 8;
  localparam int CNT_W   = 8;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 sym_valid, sym_ctrl, sym_err, pkt_ack;
  logic [7:0]           sym_byte;
  logic                 pkt_ready, frame_sync, scr_reset;
  logic [PKT_LEN*8-1:0] pkt_data;
  logic [CNT_W-1:0]     dec_err_cnt, rx_ovf_cnt, proc_ovf_cnt;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sym_framer #(.PKT_LEN(PKT_LEN), .CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_valid    (sym_valid),
    .sym_ctrl     (sym_ctrl),
    .sym_err      (sym_err),
    .sym_byte     (sym_byte),
    .pkt_ack      (pkt_ack),
    .pkt_ready    (pkt_ready),
    .pkt_data     (pkt_data),
    .frame_sync   (frame_sync),
    .scr_reset    (scr_reset),
    .dec_err_cnt  (dec_err_cnt),
    .rx_ovf_cnt   (rx_ovf_cnt),
    .proc_ovf_cnt (proc_ovf_cnt)
  );

  // Vector: [14]valid [13]ctrl [12]err [11:4]byte [3]ack | [2]ready [1]sync [0]scr_reset
  localparam logic [14:0] VEC [15] = '{
    {1'b1, 1'b0, 1'b0, 8'h11, 1'b0, 3'b000},  // data while unsynced (R7)
    {1'b1, 1'b1, 1'b0, 8'hFB, 1'b0, 3'b000},  // restart unsynced (R3)
    {1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 3'b011},  // start (R2)
    {1'b1, 1'b0, 1'b0, 8'hA0, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA1, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA2, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA3, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA4, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA6, 1'b0, 3'b010},
    {1'b1, 1'b0, 1'b0, 8'hA7, 1'b0, 3'b110},  // last byte (R5)
    {1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 3'b100},  // processing overflow (R8)
    {1'b1, 1'b1, 1'b0, 8'h3C, 1'b0, 3'b111},  // start, packet still held
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'b010},  // acknowledge (R6)
    {1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'b010}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Drive one symbol for one cycle; returns at the next negedge
  task automatic apply(input logic v, input logic c, input logic e,
                       input logic [7:0] b, input logic a);
    sym_valid = v; sym_ctrl = c; sym_err = e; sym_byte = b; pkt_ack = a;
    @(negedge clk);
    sym_valid = 1'b0; sym_ctrl = 1'b0; sym_err = 1'b0; sym_byte = '0; pkt_ack = 1'b0;
  endtask

  task automatic send_pkt(input logic [7:0] base);
    for (int k = 0; k < PKT_LEN; k++) apply(1'b1, 1'b0, 1'b0, 8'(base + 8'(k)), 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sym_valid = 1'b0; sym_ctrl = 1'b0; sym_err = 1'b0; sym_byte = '0; pkt_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 pkt_ready", 64'(pkt_ready), 64'd0);
    chk("R1 frame_sync", 64'(frame_sync), 64'd0);
    chk("R1 scr_reset", 64'(scr_reset), 64'd0);
    chk("R1 pkt_data", pkt_data, 64'd0);
    chk("R1 counters", 64'({dec_err_cnt, rx_ovf_cnt, proc_ovf_cnt}), 64'd0);

    // Table walk (R2 R3 R5 R6 R7 R8)
    for (int i = 0; i < 15; i++) begin
      apply(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:4], VEC[i][3]);
      checks++;
      if ({pkt_ready, frame_sync, scr_reset} !== VEC[i][2:0]) begin
        failures++;
        $display("FAIL table row %0d (R2/R3/R5/R6/R7/R8) actual=%b expected=%b",
                 i, {pkt_ready, frame_sync, scr_reset}, VEC[i][2:0]);
      end
    end
    chk("R8 buffer untouched by overflow", pkt_data, 64'hA7A6A5A4A3A2A1A0);
    chk("R8 proc_ovf_cnt", 64'(proc_ovf_cnt), 64'd1);
    chk("R7 rx/dec counters quiet", 64'({rx_ovf_cnt, dec_err_cnt}), 64'd0);

    // R3 restart while synced rewinds the position
    apply(1'b1, 1'b0, 1'b0, 8'hB0, 1'b0);
    apply(1'b1, 1'b0, 1'b0, 8'hB1, 1'b0);
    apply(1'b1, 1'b0, 1'b0, 8'hB2, 1'b0);
    apply(1'b1, 1'b1, 1'b0, 8'hFB, 1'b0);
    chk("R3 sync kept on restart", 64'(frame_sync), 64'd1);
    send_pkt(8'hC0);
    chk("R3 ready after restart", 64'(pkt_ready), 64'd1);
    chk("R3 packet after restart", pkt_data, 64'hC7C6C5C4C3C2C1C0);

    // R9 receive overflow after acknowledged full buffer
    apply(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    apply(1'b1, 1'b0, 1'b0, 8'h77, 1'b0);
    chk("R9 rx_ovf_cnt", 64'(rx_ovf_cnt), 64'd1);
    chk("R9 sync dropped", 64'(frame_sync), 64'd0);
    chk("R9 buffer unchanged", pkt_data, 64'hC7C6C5C4C3C2C1C0);

    // R8 data in the same cycle as ack still overflows; R2 pulse is one cycle
    apply(1'b1, 1'b1, 1'b0, 8'h3C, 1'b0);
    chk("R2 scr_reset high", 64'(scr_reset), 64'd1);
    send_pkt(8'hD0);
    chk("R2 scr_reset one cycle", 64'(scr_reset), 64'd0);
    chk("R5 packet D", pkt_data, 64'hD7D6D5D4D3D2D1D0);
    apply(1'b1, 1'b0, 1'b0, 8'h99, 1'b1);
    chk("R8 proc_ovf with ack", 64'(proc_ovf_cnt), 64'd2);
    chk("R8 ready cleared by ack", 64'(pkt_ready), 64'd0);
    chk("R8 sync dropped", 64'(frame_sync), 64'd0);

    // R10 decode errors leave framing alone
    apply(1'b1, 1'b1, 1'b0, 8'h3C, 1'b0);
    apply(1'b1, 1'b1, 1'b1, 8'h3C, 1'b0);
    chk("R10 dec_err_cnt", 64'(dec_err_cnt), 64'd1);
    chk("R10 no scr_reset on error", 64'(scr_reset), 64'd0);
    chk("R10 sync kept", 64'(frame_sync), 64'd1);
    apply(1'b1, 1'b0, 1'b1, 8'h42, 1'b0);
    chk("R10 dec_err_cnt second", 64'(dec_err_cnt), 64'd2);

    // R12 invalid strobe ignored
    apply(1'b0, 1'b1, 1'b0, 8'h55, 1'b0);
    chk("R12 sync kept when not valid", 64'(frame_sync), 64'd1);
    send_pkt(8'hE0);
    chk("R10 position not advanced by errors", pkt_data, 64'hE7E6E5E4E3E2E1E0);
    chk("R10 ready", 64'(pkt_ready), 64'd1);

    // R4 other control drops sync
    apply(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    apply(1'b1, 1'b1, 1'b0, 8'h55, 1'b0);
    chk("R4 sync dropped", 64'(frame_sync), 64'd0);

    // R7 unsynced data quiet
    apply(1'b1, 1'b0, 1'b0, 8'h12, 1'b0);
    chk("R7 counters unchanged",
        64'({dec_err_cnt, rx_ovf_cnt, proc_ovf_cnt}), 64'({8'd2, 8'd1, 8'd2}));
    chk("R7 no ready", 64'(pkt_ready), 64'd0);

    // R11 saturation
    for (int n = 0; n < 260; n++) apply(1'b1, 1'b0, 1'b1, 8'h00, 1'b0);
    chk("R11 dec_err_cnt saturates", 64'(dec_err_cnt), 64'd255);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule